// File: doc/BRIEF.md
# Triggered Switch-State Register Bank

This block is the register file that sits behind a serial control interface for a two-antenna RF switch. The bus decoder in front of it hands over single-cycle write and read strobes with a 5-bit address. The block keeps one switch-state code for each antenna side. Each code has a shadow copy and an active copy. A write lands in the shadow, and the active copy, which drives the switch, follows either at once or only when a trigger is written. Which of the two happens depends on a per-register mask.

Three other registers sit beside the two switch-state registers:

- A status register. It holds sticky error flags, which the decoder sets and which clear when the register is read. It also holds a self-clearing software-reset bit.
- A group ID register.
- A power/trigger register. It holds the power-mode field, the trigger masks and the trigger strobes.

Any power mode other than active forces both switch outputs to their isolation codes. The stored codes are not changed by this. Read data is registered.

Top module: `swreg_bank`

## Requirements
- R1: After hardware reset, both stored switch codes are 0, and the power/trigger register (address 0x1C) reads 0x01. That value is the default low-power mode, so `low_power` is 1.
- R2: Addresses 0x00 (antenna 1) and 0x01 (antenna 2) keep only bits [2:0] of a write. Bits [7:3] always read 0. A read returns the active code on `rdata` one edge after `rd_en`.
- R3: When the mask bit for a switch register is 1, a write to that register updates the active code on the same edge. Bit 2 of 0x1C is the mask for antenna 1 and bit 3 is the mask for antenna 2.
- R4: When the mask bit is 0, a write changes only the shadow, and the output holds its value. Writing 0x1C with bit 5 set copies the antenna-1 shadow to active. Writing 0x1C with bit 6 set does the same for antenna 2.
- R5: Writing 0x1C with bit 7 set copies both shadows to active, unless the stored bit 4 (the global-trigger mask) is 1. In that case the write has no trigger effect.
- R6: Bits [7:5] of 0x1C are strobes and always read 0. Bits [4:2] (masks) and [1:0] (power mode) read back as written.
- R7: While the power mode (0x1C bits [1:0]) is not 00, `low_power` is 1, `ant1_state` shows 1 and `ant2_state` shows 7. Returning to 00 shows the stored codes again.
- R8: A pulse on `err_parity` sets status bit 6, and a pulse on `err_length` sets status bit 5. Reading 0x1A returns the flags and clears them.
- R9: Writing 0x1A with bit 7 set returns every register to its reset value on the following edge, and the bit then reads 0.
- R10: The group ID register at 0x1B stores bits [7:4] of a write. Bits [3:0] read 0.
- R11: Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the bus decoder |
| rd_en | input | 1 | Read strobe from the bus decoder |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| err_parity | input | 1 | Command parity error pulse |
| err_length | input | 1 | Command length error pulse |
| rdata | output | 8 | Registered read data |
| ant1_state | output | 3 | Effective antenna-1 switch code |
| ant2_state | output | 3 | Effective antenna-2 switch code |
| low_power | output | 1 | High while the power mode is not active |

## Verification
Each result has a fixed latency:

- A write or a trigger shows on the switch outputs and on `low_power` after the one edge that captures the strobe.
- Read data appears one edge after `rd_en`.
- A software reset takes effect one edge later than an ordinary write, so its results are due two edges after the write is presented.

The bench drives every strobe on a falling edge and removes it on the next falling edge. It samples outputs on that second falling edge, or one falling edge later for the software reset, so that each sample falls exactly where its result is due.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 5;
    localparam int N_SLOT = 2;
    localparam int GSID_W = 4;

    localparam logic [ADDR_W-1:0] A_SW0  = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h1A;
    localparam logic [ADDR_W-1:0] A_GSID = 5'h1B;
    localparam logic [ADDR_W-1:0] A_PM   = 5'h1C;

    localparam int MASK_LSB = 2;
    localparam int TRIG_LSB = 5;
    localparam int SRST_BIT = 7;

    localparam logic [1:0] PWR_ACTIVE = 2'b00;
    localparam logic [1:0] PWR_RESET  = 2'b01;

    typedef struct packed {
        logic [N_SLOT:0] mask;
        logic [1:0]      pwr;
    } pm_t;

    typedef struct packed {
        logic parity;
        logic length;
    } flags_t;

    function automatic logic [DATA_W-1:0] pm_word(input pm_t p);
        return {{(DATA_W-$bits(pm_t)){1'b0}}, p};
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input logic srst, input flags_t f);
        return {srst, f.parity, f.length, {(DATA_W-3){1'b0}}};
    endfunction
endpackage

// File: rtl/swreg_slot.sv
module swreg_slot #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         srst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         immediate,
    input  logic         trig,
    output logic [W-1:0] active_o
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    always_ff @(posedge clk) begin
        if (srst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_en)
                shadow_q <= wdata;
            if (wr_en && immediate)
                active_q <= wdata;
            else if (trig)
                active_q <= shadow_q;
        end
    end

    assign active_o = active_q;
endmodule

// File: rtl/swreg_ctrl.sv
module swreg_ctrl import swreg_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err_parity,
    input  logic              err_length,
    output pm_t               pm_o,
    output logic [GSID_W-1:0] gsid_o,
    output logic              swrst_o,
    output flags_t            flags_o,
    output logic [N_SLOT:0]   trig_o
);
    pm_t               pm_q;
    flags_t            flags_q;
    logic [GSID_W-1:0] gsid_q;
    logic              swrst_q;
    logic              sreset;
    logic              wr_pm;
    logic              wr_stat;
    logic              wr_gsid;
    logic              rd_stat;

    assign sreset  = rst | swrst_q;
    assign wr_pm   = wr_en && (addr == A_PM);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_gsid = wr_en && (addr == A_GSID);
    assign rd_stat = rd_en && (addr == A_STAT);

    always_ff @(posedge clk) begin
        if (sreset) begin
            pm_q    <= '{mask: '0, pwr: PWR_RESET};
            flags_q <= '0;
            gsid_q  <= '0;
            swrst_q <= 1'b0;
        end else begin
            if (wr_pm) begin
                pm_q.pwr  <= wdata[1:0];
                pm_q.mask <= wdata[MASK_LSB +: N_SLOT+1];
            end
            if (wr_gsid)
                gsid_q <= wdata[DATA_W-1 -: GSID_W];
            if (wr_stat && wdata[SRST_BIT])
                swrst_q <= 1'b1;
            flags_q.parity <= (flags_q.parity & ~rd_stat) | err_parity;
            flags_q.length <= (flags_q.length & ~rd_stat) | err_length;
        end
    end

    generate
        for (genvar g = 0; g < N_SLOT; g++) begin : g_trig
            assign trig_o[g] = wr_pm && wdata[TRIG_LSB + g];
        end
    endgenerate
    assign trig_o[N_SLOT] = wr_pm && wdata[TRIG_LSB + N_SLOT] && !pm_q.mask[N_SLOT];

    assign pm_o    = pm_q;
    assign gsid_o  = gsid_q;
    assign swrst_o = swrst_q;
    assign flags_o = flags_q;
endmodule

// File: rtl/swreg_bank.sv
module swreg_bank import swreg_pkg::*; #(
    parameter int                 STATE_W = 3,
    parameter logic [STATE_W-1:0] ISO1    = 1,
    parameter logic [STATE_W-1:0] ISO2    = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               err_parity,
    input  logic               err_length,
    output logic [DATA_W-1:0]  rdata,
    output logic [STATE_W-1:0] ant1_state,
    output logic [STATE_W-1:0] ant2_state,
    output logic               low_power
);
    localparam int PAD_W = DATA_W - STATE_W;

    pm_t               pm;
    flags_t            flags;
    logic [GSID_W-1:0] gsid;
    logic              swrst;
    logic              sreset;
    logic [N_SLOT:0]   trig;
    logic [STATE_W-1:0] active [N_SLOT];
    logic [DATA_W-1:0] rd_next;

    assign sreset = rst | swrst;

    swreg_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .err_parity (err_parity),
        .err_length (err_length),
        .pm_o       (pm),
        .gsid_o     (gsid),
        .swrst_o    (swrst),
        .flags_o    (flags),
        .trig_o     (trig)
    );

    generate
        for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
            swreg_slot #(.W(STATE_W)) u_slot (
                .clk       (clk),
                .srst      (sreset),
                .wr_en     (wr_en && (addr == A_SW0 + ADDR_W'(g))),
                .wdata     (wdata[STATE_W-1:0]),
                .immediate (pm.mask[g]),
                .trig      (trig[g] | trig[N_SLOT]),
                .active_o  (active[g])
            );
        end
    endgenerate

    always_comb begin
        case (addr)
            A_SW0:                 rd_next = {{PAD_W{1'b0}}, active[0]};
            A_SW0 + ADDR_W'(1):    rd_next = {{PAD_W{1'b0}}, active[1]};
            A_STAT:                rd_next = stat_word(swrst, flags);
            A_GSID:                rd_next = {gsid, {(DATA_W-GSID_W){1'b0}}};
            A_PM:                  rd_next = pm_word(pm);
            default:               rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (sreset)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end

    assign low_power  = (pm.pwr != PWR_ACTIVE);
    assign ant1_state = low_power ? ISO1 : active[0];
    assign ant2_state = low_power ? ISO2 : active[1];
endmodule

// File: rtl/swreg_bank_chk.sv
module swreg_bank_chk import swreg_pkg::*; #(
    parameter int                 STATE_W = 3,
    parameter logic [STATE_W-1:0] ISO1    = 1,
    parameter logic [STATE_W-1:0] ISO2    = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               wdata_msb,
    input logic [DATA_W-1:0]  rdata,
    input logic [STATE_W-1:0] ant1_state,
    input logic [STATE_W-1:0] ant2_state,
    input logic               low_power
);
    logic mapped;
    assign mapped = (addr == A_SW0) || (addr == A_SW0 + ADDR_W'(1)) ||
                    (addr == A_STAT) || (addr == A_GSID) || (addr == A_PM);

    AST_LP_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        low_power |-> (ant1_state == ISO1 && ant2_state == ISO2)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !low_power) |=> (low_power || ($stable(ant1_state) && $stable(ant2_state)))); // R4

    AST_SW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == A_SW0 || addr == A_SW0 + ADDR_W'(1))) |=> (rdata[DATA_W-1:STATE_W] == '0)); // R2

    AST_TRIG_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_PM) |=> (rdata[DATA_W-1:TRIG_LSB] == '0)); // R6

    AST_SWRST_LP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STAT && wdata_msb) |=> ##1 low_power); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !mapped) |=> (rdata == '0)); // R11
endmodule

bind swreg_bank swreg_bank_chk #(.STATE_W(STATE_W), .ISO1(ISO1), .ISO2(ISO2)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata_msb  (wdata[swreg_pkg::DATA_W-1]),
    .rdata      (rdata),
    .ant1_state (ant1_state),
    .ant2_state (ant2_state),
    .low_power  (low_power)
);

// File: tb/swreg_bank_tb.sv
module swreg_bank_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       err_parity = 1'b0;
    logic       err_length = 1'b0;
    logic [7:0] rdata;
    logic [2:0] ant1_state;
    logic [2:0] ant2_state;
    logic       low_power;

    int total = 0;
    int bad = 0;
    int exp1 = 0;
    int exp2 = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    swreg_bank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .err_parity(err_parity), .err_length(err_length),
        .rdata(rdata), .ant1_state(ant1_state), .ant2_state(ant2_state),
        .low_power(low_power)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic pulse(input logic p, input logic l);
        @(negedge clk); err_parity = p; err_length = l;
        @(negedge clk); err_parity = 1'b0; err_length = 1'b0;
    endtask

    task automatic outs(input string req, input int e1, input int e2, input int elp);
        check(req, ant1_state, e1);
        check(req, ant2_state, e2);
        check(req, low_power, elp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        outs("R1", 1, 7, 1);
        rd(5'h1C, rv); check("R1 pm", rv, 8'h01);
        rd(5'h00, rv); check("R1 sw0", rv, 0);
        rd(5'h01, rv); check("R1 sw1", rv, 0);

        // active mode, both masks set: immediate writes
        wr(5'h1C, 8'h0C);
        outs("R7 active", 0, 0, 0);
        for (int v = 0; v < 256; v++) begin
            wr(5'h00, 8'(v));
            check("R3 ant1", ant1_state, v % 8);
            rd(5'h00, rv); check("R2 sw0", rv, v % 8);
        end
        for (int v = 0; v < 256; v++) begin
            wr(5'h01, 8'(v));
            check("R3 ant2", ant2_state, v % 8);
            rd(5'h01, rv); check("R2 sw1", rv, v % 8);
        end
        exp1 = 7; exp2 = 7;

        // masks clear: shadow then per-register trigger
        wr(5'h1C, 8'h00);
        for (int k = 0; k < 8; k++) begin
            wr(5'h00, 8'(k));
            check("R4 held1", ant1_state, exp1);
            wr(5'h1C, 8'h20);
            exp1 = k;
            check("R4 trig1", ant1_state, exp1);
            check("R4 other", ant2_state, exp2);
            rd(5'h1C, rv); check("R6 pm", rv, 8'h00);
        end
        for (int k = 7; k >= 0; k--) begin
            wr(5'h01, 8'(k));
            check("R4 held2", ant2_state, exp2);
            wr(5'h1C, 8'h40);
            exp2 = k;
            check("R4 trig2", ant2_state, exp2);
            check("R4 other", ant1_state, exp1);
        end

        // global trigger and its mask
        wr(5'h00, 8'h03);
        wr(5'h01, 8'h05);
        outs("R5 before", exp1, exp2, 0);
        wr(5'h1C, 8'h80);
        outs("R5 global", 3, 5, 0);
        wr(5'h1C, 8'h10);
        wr(5'h00, 8'h06);
        wr(5'h1C, 8'h90);
        check("R5 masked", ant1_state, 3);
        rd(5'h1C, rv); check("R6 pm mask", rv, 8'h10);
        wr(5'h1C, 8'h30);
        check("R4 trig under mask2", ant1_state, 6);

        // power modes
        wr(5'h1C, 8'h01);
        outs("R7 lp01", 1, 7, 1);
        rd(5'h00, rv); check("R7 kept", rv, 6);
        wr(5'h1C, 8'h02);
        outs("R7 lp10", 1, 7, 1);
        wr(5'h1C, 8'h03);
        outs("R7 lp11", 1, 7, 1);
        wr(5'h1C, 8'h00);
        outs("R7 restore", 6, 5, 0);

        // status flags
        pulse(1'b1, 1'b0);
        rd(5'h1A, rv); check("R8 parity", rv, 8'h40);
        rd(5'h1A, rv); check("R8 cleared", rv, 8'h00);
        pulse(1'b0, 1'b1);
        rd(5'h1A, rv); check("R8 length", rv, 8'h20);
        pulse(1'b1, 1'b1);
        rd(5'h1A, rv); check("R8 both", rv, 8'h60);
        rd(5'h1A, rv); check("R8 cleared2", rv, 8'h00);

        // group ID
        wr(5'h1B, 8'hA5);
        rd(5'h1B, rv); check("R10 gsid", rv, 8'hA0);

        // unmapped addresses
        wr(5'h05, 8'hFF);
        wr(5'h1F, 8'hFF);
        rd(5'h05, rv); check("R11 read", rv, 0);
        rd(5'h1F, rv); check("R11 read", rv, 0);
        outs("R11 outputs", 6, 5, 0);
        rd(5'h1C, rv); check("R11 pm", rv, 8'h00);

        // software reset
        pulse(1'b1, 1'b0);
        wr(5'h1A, 8'h80);
        @(negedge clk);
        outs("R9 swrst", 1, 7, 1);
        rd(5'h1A, rv); check("R9 status", rv, 8'h00);
        rd(5'h1B, rv); check("R9 gsid", rv, 8'h00);
        rd(5'h1C, rv); check("R9 pm", rv, 8'h01);
        wr(5'h1C, 8'h00);
        outs("R9 stored", 0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule